// File: doc/BRIEF.md
# Refresh-Slot ECC Scrubber

This block cleans soft errors out of an error-protected DRAM array a little at a time. It does the work only inside refresh slots. Each pulse on the refresh tick input starts one scrub transaction. The controller requests the memory port and reads the codeword at its current scrub address. It then decodes the word with a built-in single-error-correct, double-error-detect (SEC-DED) Hamming check.

- A clean word needs nothing more, so the slot is released straight after the read.
- A word with one flipped bit is written back in corrected form, and the corrected-error counter increments.
- A word with two or more errors is left untouched. Its address is captured in an error register, a sticky flag is raised, and the uncorrectable counter increments.

After every transaction the scrub address steps forward by one. When it passes the last address of the configured range it returns to the base address, and a one-cycle pass-complete pulse marks the end of the sweep. The range is set with two inputs that stay static while the block is out of reset. A refresh tick that arrives while a transaction is still waiting for the memory grant is not queued. It only increments a missed-tick counter.

Top module: `ecc_scrubber`

## Requirements
- R1: Each accepted refresh tick causes exactly one read of the current scrub address. The request goes up in the cycle after the tick is sampled and holds its address and direction steady until the grant.
- R2: The codeword has DATA_W+P+1 bits, where P is the smallest count with 2^P >= DATA_W+P+1.
  - Bit 0 is even parity over the whole word.
  - Positions 1 and up that are powers of two hold check bits. The check bit at 2^k makes the XOR of all positions with bit k set equal to zero.
  - Data bits fill the remaining positions in ascending order.
  - A word with exactly one flipped bit, including bit 0, is rewritten at the same address with the corrected value, and the corrected counter increments.
- R3: A clean word causes no write, and the busy output falls when the check cycle ends.
- R4: A word with two flipped bits is not written. Its address is loaded into the error-address output, the error flag rises and stays high until reset, and the uncorrectable counter increments.
- R5: Scrub addresses go from cfg_base up to cfg_last one per transaction and then wrap back to cfg_base. The wrap produces a pass_done pulse exactly one cycle long.
- R6: A refresh tick sampled while a transaction is in progress starts no extra read and increments the missed counter by one.
- R7: All three counters saturate at 2^CNT_W-1 instead of wrapping.
- R8: Reset leaves the block idle with no request, all counters at zero, the error flag low, and the next scrub starting at cfg_base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_tick | input | 1 | One-cycle pulse per refresh slot |
| cfg_base | input | ADDR_W | First address of the scrub range |
| cfg_last | input | ADDR_W | Last address of the scrub range |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | CW | Corrected codeword for write-back |
| mem_gnt | input | 1 | Access completes at an edge where mem_req and mem_gnt are both high |
| mem_rdata | input | CW | Read codeword, valid while mem_gnt is high |
| scrub_busy | output | 1 | A scrub transaction holds the refresh slot |
| pass_done | output | 1 | One-cycle pulse after the address wraps |
| corr_cnt | output | CNT_W | Saturating count of corrected words |
| uncorr_cnt | output | CNT_W | Saturating count of uncorrectable words |
| miss_cnt | output | CNT_W | Saturating count of missed ticks |
| err_flag | output | 1 | Sticky uncorrectable-error flag |
| err_addr | output | ADDR_W | Address of the latest uncorrectable word |

## Verification
The states are IDLE, READ, CHECK and WRITE. The transitions are IDLE to READ on a tick, READ to CHECK on the grant, CHECK to WRITE for a single error, CHECK to IDLE otherwise, and WRITE to IDLE on the grant.

With the grant given at once, the read completes at the second edge after the tick is sampled. The counters, the error register, busy and the address step settle at the third edge. A write-back completes at the fourth edge, and pass_done is high for the cycle after the advancing edge. The bench therefore drives the tick for one cycle from a falling edge, waits six more cycles, and samples only at falling edges. For the missed-tick case it withholds the grant, samples while the request is still pending, and then waits well past the point where a queued read would have appeared.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CHECK = 2'd2,
        ST_WRITE = 2'd3
    } scrub_state_e;

    typedef enum logic [1:0] {
        V_CLEAN  = 2'd0,
        V_SINGLE = 2'd1,
        V_DOUBLE = 2'd2
    } verdict_e;

    function automatic int check_bits(input int data_w);
        int p;
        p = 0;
        for (int k = 0; k < 16; k++) begin
            if ((1 << p) < data_w + p + 1) p = p + 1;
        end
        return p;
    endfunction

    function automatic int code_width(input int data_w);
        return data_w + check_bits(data_w) + 1;
    endfunction

endpackage

// File: rtl/scrub_secded.sv
module scrub_secded #(
    parameter int DATA_W = 32
) (
    input  logic [scrub_pkg::code_width(DATA_W)-1:0] word_in,
    output logic [scrub_pkg::code_width(DATA_W)-1:0] word_fixed,
    output scrub_pkg::verdict_e                      verdict
);
    localparam int CW = scrub_pkg::code_width(DATA_W);
    localparam int SW = scrub_pkg::check_bits(DATA_W);

    logic [SW-1:0] syn;
    logic          odd;
    logic          fixable;
    logic [CW-1:0] flip;

    always_comb begin
        syn = '0;
        for (int i = 1; i < CW; i++) begin
            if (word_in[i]) syn = syn ^ SW'(i);
        end
        odd     = ^word_in;
        fixable = odd && (int'(syn) < CW);
        for (int i = 0; i < CW; i++) begin
            flip[i] = fixable && (syn == SW'(i));
        end
        word_fixed = word_in ^ flip;
        if (!odd) verdict = (syn == '0) ? scrub_pkg::V_CLEAN : scrub_pkg::V_DOUBLE;
        else      verdict = fixable ? scrub_pkg::V_SINGLE : scrub_pkg::V_DOUBLE;
    end
endmodule

// File: rtl/scrub_addr_gen.sv
module scrub_addr_gen #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_last,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    logic [ADDR_W-1:0] offset_q;
    logic              at_end;

    assign addr   = cfg_base + offset_q;
    assign at_end = (addr >= cfg_last);
    assign wrap   = advance && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       offset_q <= '0;
        else if (advance) offset_q <= at_end ? '0 : offset_q + 1'b1;
    end
endmodule

// File: rtl/scrub_sat_cnt.sv
module scrub_sat_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   count <= '0;
        else if (inc && count != '1)  count <= count + 1'b1;
    end
endmodule

// File: rtl/ecc_scrubber.sv
module ecc_scrubber #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     refresh_tick,
    input  logic [ADDR_W-1:0]                        cfg_base,
    input  logic [ADDR_W-1:0]                        cfg_last,
    output logic                                     mem_req,
    output logic                                     mem_we,
    output logic [ADDR_W-1:0]                        mem_addr,
    output logic [scrub_pkg::code_width(DATA_W)-1:0] mem_wdata,
    input  logic                                     mem_gnt,
    input  logic [scrub_pkg::code_width(DATA_W)-1:0] mem_rdata,
    output logic                                     scrub_busy,
    output logic                                     pass_done,
    output logic [CNT_W-1:0]                         corr_cnt,
    output logic [CNT_W-1:0]                         uncorr_cnt,
    output logic [CNT_W-1:0]                         miss_cnt,
    output logic                                     err_flag,
    output logic [ADDR_W-1:0]                        err_addr
);
    import scrub_pkg::*;

    localparam int CW     = code_width(DATA_W);
    localparam int N_CNT  = 3;

    scrub_state_e      state_q, state_d;
    logic [CW-1:0]     word_q;
    logic [CW-1:0]     word_fixed;
    verdict_e          verdict;
    logic [ADDR_W-1:0] scrub_addr;
    logic              advance, wrap;
    logic              in_check;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    scrub_secded #(.DATA_W(DATA_W)) u_dec (
        .word_in    (word_q),
        .word_fixed (word_fixed),
        .verdict    (verdict)
    );

    scrub_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .cfg_base (cfg_base),
        .cfg_last (cfg_last),
        .addr     (scrub_addr),
        .wrap     (wrap)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (refresh_tick) state_d = ST_READ;
            ST_READ:  if (mem_gnt)      state_d = ST_CHECK;
            ST_CHECK: state_d = (verdict == V_SINGLE) ? ST_WRITE : ST_IDLE;
            ST_WRITE: if (mem_gnt)      state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        advance    = 1'b0;
        in_check   = 1'b0;
        scrub_busy = 1'b1;
        unique case (state_q)
            ST_IDLE:  scrub_busy = 1'b0;
            ST_READ:  mem_req = 1'b1;
            ST_CHECK: begin
                in_check = 1'b1;
                advance  = (verdict != V_SINGLE);
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                advance = mem_gnt;
            end
            default:  scrub_busy = 1'b0;
        endcase
    end

    assign mem_addr  = scrub_addr;
    assign mem_wdata = word_fixed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q    <= '0;
            pass_done <= 1'b0;
            err_flag  <= 1'b0;
            err_addr  <= '0;
        end else begin
            pass_done <= wrap;
            if (state_q == ST_READ && mem_gnt) word_q <= mem_rdata;
            if (in_check && verdict == V_DOUBLE) begin
                err_flag <= 1'b1;
                err_addr <= scrub_addr;
            end
        end
    end

    assign cnt_inc[0] = in_check && (verdict == V_SINGLE);
    assign cnt_inc[1] = in_check && (verdict == V_DOUBLE);
    assign cnt_inc[2] = refresh_tick && (state_q != ST_IDLE);

    generate
        for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
            scrub_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (cnt_inc[g]),
                .count (cnt_val[g])
            );
        end
    endgenerate

    assign corr_cnt   = cnt_val[0];
    assign uncorr_cnt = cnt_val[1];
    assign miss_cnt   = cnt_val[2];
endmodule

// File: rtl/ecc_scrubber_checker.sv
module ecc_scrubber_checker #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] cfg_base,
    input logic [ADDR_W-1:0] cfg_last,
    input logic              pass_done,
    input logic              err_flag,
    input logic [CNT_W-1:0]  corr_cnt
);
    AST_ONE_READ_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_gnt) |=> !(mem_req && !mem_we)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R1

    AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> $stable(mem_addr)); // R2

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cfg_base <= cfg_last) |-> (mem_addr >= cfg_base && mem_addr <= cfg_last)); // R5

    AST_PASS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_cnt == '1) |=> (corr_cnt == '1)); // R7
endmodule

bind ecc_scrubber ecc_scrubber_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .cfg_base  (cfg_base),
    .cfg_last  (cfg_last),
    .pass_done (pass_done),
    .err_flag  (err_flag),
    .corr_cnt  (corr_cnt)
);

// File: tb/tb_ecc_scrubber.sv
module tb_ecc_scrubber;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int CN = 3;
    localparam int CW = 39;
    localparam logic [AW-1:0] BASE = 8'd4;
    localparam logic [AW-1:0] LAST = 8'd11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_tick = 1'b0;
    logic          gnt_en = 1'b1;
    logic          mem_req, mem_we, mem_gnt;
    logic [AW-1:0] mem_addr;
    logic [CW-1:0] mem_wdata, mem_rdata;
    logic          scrub_busy, pass_done, err_flag;
    logic [CN-1:0] corr_cnt, uncorr_cnt, miss_cnt;
    logic [AW-1:0] err_addr;

    logic [CW-1:0] mem [256];
    int rd_cnt = 0, wr_cnt = 0, pass_cnt = 0;
    logic [AW-1:0] last_rd = '0, last_wr = '0;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    ecc_scrubber #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CN)) dut (
        .clk(clk), .rst_n(rst_n), .refresh_tick(refresh_tick),
        .cfg_base(BASE), .cfg_last(LAST),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .scrub_busy(scrub_busy), .pass_done(pass_done),
        .corr_cnt(corr_cnt), .uncorr_cnt(uncorr_cnt), .miss_cnt(miss_cnt),
        .err_flag(err_flag), .err_addr(err_addr)
    );

    assign mem_gnt   = mem_req && gnt_en;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && mem_gnt) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt  <= wr_cnt + 1;
                last_wr <= mem_addr;
            end else begin
                rd_cnt  <= rd_cnt + 1;
                last_rd <= mem_addr;
            end
        end
        if (pass_done) pass_cnt <= pass_cnt + 1;
    end

    function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
        logic [CW-1:0] w;
        int j;
        w = '0;
        j = 0;
        for (int pos = 1; pos < CW; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                w[pos] = d[j];
                j++;
            end
        end
        for (int k = 0; k < 6; k++) begin
            logic par;
            par = 1'b0;
            for (int pos = 1; pos < CW; pos++)
                if (((pos >> k) & 1) == 1 && pos != (1 << k)) par = par ^ w[pos];
            w[1 << k] = par;
        end
        w[0] = ^w[CW-1:1];
        return w;
    endfunction

    function automatic logic [DW-1:0] pat(input int a);
        return 32'hA5C3_0000 ^ (a * 32'h0101_1F3D);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic scrub();
        @(negedge clk) refresh_tick = 1'b1;
        @(negedge clk) refresh_tick = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R8", "busy", scrub_busy, 0);
        chk("R8", "req", mem_req, 0);
        chk("R8", "counters", {corr_cnt, uncorr_cnt, miss_cnt}, 0);
        chk("R8", "err_flag", err_flag, 0);
        chk("R8", "pass_done", pass_done, 0);
    endtask

    task automatic t_clean();
        int r0 = rd_cnt, w0 = wr_cnt;
        scrub();
        chk("R1", "reads per tick", rd_cnt - r0, 1);
        chk("R1", "first addr", last_rd, BASE);
        chk("R3", "no write", wr_cnt - w0, 0);
        chk("R3", "busy released", scrub_busy, 0);
    endtask

    task automatic t_single(input int a, input int bitpos, input int exp_corr);
        int w0 = wr_cnt;
        mem[a] = enc(pat(a)) ^ (39'd1 << bitpos);
        scrub();
        chk("R2", "rewritten word", mem[a], enc(pat(a)));
        chk("R2", "write count", wr_cnt - w0, 1);
        chk("R2", "write addr", last_wr, a);
        chk("R2", "corr_cnt", corr_cnt, exp_corr);
    endtask

    task automatic t_double();
        logic [CW-1:0] bad = enc(pat(7)) ^ (39'd1 << 3) ^ (39'd1 << 20);
        int w0 = wr_cnt;
        mem[7] = bad;
        scrub();
        chk("R4", "word untouched", mem[7], bad);
        chk("R4", "no write", wr_cnt - w0, 0);
        chk("R4", "uncorr_cnt", uncorr_cnt, 1);
        chk("R4", "err_flag", err_flag, 1);
        chk("R4", "err_addr", err_addr, 7);
    endtask

    task automatic t_wrap();
        scrub(); scrub(); scrub();
        chk("R5", "addr 10 read", last_rd, 10);
        chk("R5", "no early pass", pass_cnt, 0);
        scrub();
        chk("R5", "last addr read", last_rd, LAST);
        chk("R5", "one pass pulse", pass_cnt, 1);
        scrub();
        chk("R5", "wrapped to base", last_rd, BASE);
        chk("R4", "flag still set", err_flag, 1);
    endtask

    task automatic t_miss();
        int r0 = rd_cnt;
        gnt_en = 1'b0;
        @(negedge clk) refresh_tick = 1'b1;
        @(negedge clk) refresh_tick = 1'b0;
        repeat (3) @(negedge clk);
        refresh_tick = 1'b1;
        @(negedge clk) refresh_tick = 1'b0;
        repeat (2) @(negedge clk);
        chk("R6", "busy while pending", scrub_busy, 1);
        chk("R6", "miss_cnt", miss_cnt, 1);
        chk("R6", "no read yet", rd_cnt - r0, 0);
        gnt_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R6", "single read only", rd_cnt - r0, 1);
        chk("R6", "read addr", last_rd, 5);
        chk("R6", "idle after", scrub_busy, 0);
    endtask

    task automatic t_sat();
        for (int a = 4; a <= 11; a++) mem[a] = enc(pat(a)) ^ (39'd1 << (a + 1));
        for (int k = 0; k < 8; k++) scrub();
        chk("R7", "corr saturated", corr_cnt, 7);
        chk("R7", "uncorr unchanged", uncorr_cnt, 1);
    endtask

    task automatic t_reset_clear();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "counters cleared", {corr_cnt, uncorr_cnt, miss_cnt}, 0);
        chk("R8", "flag cleared", err_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        scrub();
        chk("R8", "restart at base", last_rd, BASE);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = enc(pat(a));
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_clean();
        t_single(5, 10, 1);
        t_single(6, 0, 2);
        t_double();
        t_wrap();
        t_miss();
        t_sat();
        t_reset_clear();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        summary();
    end
endmodule